// File: doc/BRIEF.md
# Column-Parallel 2x2 Cluster Sparsifier

This block takes one row of pixel samples per accepted transfer, with every sensor column on its own lane. It checks every 2x2 window formed by two neighbouring lanes and two successive rows. When the four samples of a window add up to at least a fixed threshold, it marks a 4x4 neighbourhood centred on that window. Only the marked pixels leave the block, one record per pixel, and each record carries its row, its column and the raw sample.

A row can be sent out only after the two rows below it have arrived, so the block keeps the two most recent rows. It also keeps the window-hit vectors of the three previous row pairs. When a row has aged enough, its readout mask is built and loaded into a serialiser. The serialiser puts the set columns, lowest first, into a small output FIFO. Input rows are held off while the serialiser still owns a row. A row tagged as end-of-frame starts two flush steps that feed in empty rows. When every record of the frame has been taken, a one-cycle frame-done pulse follows, and the block is then ready for the next frame.

Top module: `cluster_sparsifier`

## Requirements
- R1: A window whose top-left pixel is (row r, column c) covers rows r and r+1 and columns c and c+1. It is a hit when the sum of its four unsigned 5-bit samples is at least THRESHOLD (default 20). A sum one below THRESHOLD is not a hit.
- R2: Each hit window marks every pixel in rows r-1 to r+2 and columns c-1 to c+2.
- R3: Any part of a marked region that lies outside the array is dropped. Records never name a row beyond the last row of the frame or a column beyond NUM_COLS-1, and a region never wraps to the opposite edge.
- R4: A pixel that lies in several marked regions is emitted exactly once.
- R5: Records leave in row-major order: ascending row, and ascending column within a row.
- R6: A record holds the row index, counted from 0 at the first row of the frame, and the column index. Lane j sits at bits [j*5 +: 5] of `pix_data_i`. The record also holds the unmodified sample of that pixel.
- R7: Pixels outside every marked region are never emitted. A frame with no hit window produces no records.
- R8: While `rec_valid_o` is high and `rec_ready_i` is low, the record outputs hold their values. No record is lost under backpressure.
- R9: From the cycle after a row tagged with `pix_eof_i` is accepted until `frame_done_o` pulses, `pix_ready_o` stays low.
- R10: `frame_done_o` is a one-cycle pulse. It is raised only after the last record of the frame has been consumed, with `rec_valid_o` low.
- R11: After reset, `rec_valid_o` and `frame_done_o` are low and `pix_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | A row of samples is offered |
| pix_ready_o | output | 1 | The block can take a row this cycle |
| pix_eof_i | input | 1 | The offered row is the last of the frame |
| pix_data_i | input | NUM_COLS*SAMPLE_W | One sample per column lane |
| rec_valid_o | output | 1 | A pixel record is offered |
| rec_ready_i | input | 1 | Downstream takes the record |
| rec_row_o | output | ROW_W | Row index of the record |
| rec_col_o | output | $clog2(NUM_COLS) | Column index of the record |
| rec_val_o | output | SAMPLE_W | Sample value of the record |
| frame_done_o | output | 1 | One-cycle pulse after the last record of a frame |

## Verification
The serialiser can push a record into the FIFO in the same cycle that downstream pops one, and this is where the two functions can collide. The FIFO must then neither overflow nor lose a record. Frames with dense marks, such as all-full rows and noise patterns, are run with a pseudo-random `rec_ready_i`, so that the FIFO is full while pushes and pops land together. Each record is compared in order against a list computed directly from the frame. A held record is compared with itself in the next cycle. The end-of-frame flush and the draining of the FIFO also overlap, and there the check is that `frame_done_o` comes only after the final pop.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_DRAIN = 2'd2
  } step_state_e;
endpackage

// File: rtl/cf_window_hits.sv
module cf_window_hits #(
  parameter int NUM_COLS  = 8,
  parameter int SAMPLE_W  = 5,
  parameter int THRESHOLD = 20
) (
  input  logic [NUM_COLS*SAMPLE_W-1:0] upper_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0] lower_i,
  output logic [NUM_COLS-2:0]          hit_o
);
  for (genvar c = 0; c < NUM_COLS - 1; c++) begin : g_win
    logic [31:0] sum;
    assign sum = 32'(upper_i[c*SAMPLE_W +: SAMPLE_W])
               + 32'(upper_i[(c+1)*SAMPLE_W +: SAMPLE_W])
               + 32'(lower_i[c*SAMPLE_W +: SAMPLE_W])
               + 32'(lower_i[(c+1)*SAMPLE_W +: SAMPLE_W]);
    assign hit_o[c] = (sum >= 32'(THRESHOLD));
  end
endmodule

// File: rtl/cf_mark_dilate.sv
module cf_mark_dilate #(
  parameter int NUM_COLS = 8
) (
  input  logic [NUM_COLS-2:0] hit_i,
  output logic [NUM_COLS-1:0] mark_o
);
  // window at column c covers columns c-1 .. c+2, clipped at the edges
  always_comb begin
    mark_o = '0;
    for (int x = 0; x < NUM_COLS; x++) begin
      for (int c = 0; c < NUM_COLS - 1; c++) begin
        if ((c + 2 >= x) && (c <= x + 1)) mark_o[x] = mark_o[x] | hit_i[c];
      end
    end
  end
endmodule

// File: rtl/cf_emitter.sv
module cf_emitter #(
  parameter int NUM_COLS = 8,
  parameter int SAMPLE_W = 5,
  parameter int ROW_W    = 6,
  parameter int COL_W    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [ROW_W-1:0]             load_row_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0] load_data_i,
  input  logic [NUM_COLS-1:0]          load_mask_i,
  input  logic                         full_i,
  output logic                         idle_o,
  output logic                         push_o,
  output logic [ROW_W-1:0]             rec_row_o,
  output logic [COL_W-1:0]             rec_col_o,
  output logic [SAMPLE_W-1:0]          rec_val_o
);
  logic [NUM_COLS*SAMPLE_W-1:0] data_q;
  logic [NUM_COLS-1:0]          mask_q;
  logic [ROW_W-1:0]             row_q;
  logic [COL_W-1:0]             sel;

  always_comb begin
    sel = '0;
    for (int i = NUM_COLS - 1; i >= 0; i--) begin
      if (mask_q[i]) sel = COL_W'(i);
    end
  end

  assign idle_o    = (mask_q == '0);
  assign push_o    = !idle_o && !full_i;
  assign rec_row_o = row_q;
  assign rec_col_o = sel;
  assign rec_val_o = data_q[sel*SAMPLE_W +: SAMPLE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      mask_q <= '0;
      row_q  <= '0;
    end else if (load_i) begin
      data_q <= load_data_i;
      mask_q <= load_mask_i;
      row_q  <= load_row_i;
    end else if (push_o) begin
      mask_q[sel] <= 1'b0;
    end
  end

  // R9: a new row may only be taken when the previous one is fully serialised
  a_r9_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> idle_o);
endmodule

// File: rtl/cf_fifo.sv
module cf_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;
  logic             do_pop, do_push;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == (PTR_W+1)'(DEPTH));
  assign data_o  = mem_q[rd_q];
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && !full_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/cluster_sparsifier.sv
module cluster_sparsifier
  import cf_pkg::*;
#(
  parameter int NUM_COLS   = 8,
  parameter int SAMPLE_W   = 5,
  parameter int ROW_W      = 6,
  parameter int THRESHOLD  = 20,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       pix_valid_i,
  output logic                                       pix_ready_o,
  input  logic                                       pix_eof_i,
  input  logic [NUM_COLS*SAMPLE_W-1:0]               pix_data_i,
  output logic                                       rec_valid_o,
  input  logic                                       rec_ready_i,
  output logic [ROW_W-1:0]                           rec_row_o,
  output logic [((NUM_COLS>1)?$clog2(NUM_COLS):1)-1:0] rec_col_o,
  output logic [SAMPLE_W-1:0]                        rec_val_o,
  output logic                                       frame_done_o
);
  localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int ROW_BITS = NUM_COLS * SAMPLE_W;
  localparam int REC_W    = ROW_W + COL_W + SAMPLE_W;
  localparam int CNT_W    = ROW_W + 1;

  step_state_e          st_q;
  logic                 flush_second_q;
  logic [CNT_W-1:0]     k_q;          // index of the next row to arrive
  logic [ROW_BITS-1:0]  row1_q, row2_q; // rows k-1 and k-2
  logic [NUM_COLS-2:0]  h1_q, h2_q, h3_q; // hits of windows topped at k-2, k-3, k-4
  logic                 done_q;

  logic                 em_idle, em_push, fifo_full, fifo_valid;
  logic [ROW_W-1:0]     em_row;
  logic [COL_W-1:0]     em_col;
  logic [SAMPLE_W-1:0]  em_val;
  logic [REC_W-1:0]     fifo_out;

  logic                 accept, flush_step, step, load, drain_done;
  logic [NUM_COLS-2:0]  win_hit, new_h;
  logic [NUM_COLS-1:0]  mark;
  logic [ROW_W-1:0]     load_row;

  assign pix_ready_o = (st_q == ST_RUN) && em_idle;
  assign accept      = pix_valid_i && pix_ready_o;
  assign flush_step  = (st_q == ST_FLUSH) && em_idle;
  assign step        = accept || flush_step;
  assign drain_done  = (st_q == ST_DRAIN) && em_idle && !fifo_valid;

  cf_window_hits #(
    .NUM_COLS (NUM_COLS),
    .SAMPLE_W (SAMPLE_W),
    .THRESHOLD(THRESHOLD)
  ) u_hits (
    .upper_i(row1_q),
    .lower_i(pix_data_i),
    .hit_o  (win_hit)
  );

  // windows need a real row below the previous one; flush rows carry none
  assign new_h = (accept && (k_q != '0)) ? win_hit : '0;

  cf_mark_dilate #(.NUM_COLS(NUM_COLS)) u_dilate (
    .hit_i (h1_q | h2_q | h3_q | new_h),
    .mark_o(mark)
  );

  assign load     = step && (k_q >= CNT_W'(2));
  assign load_row = ROW_W'(k_q - CNT_W'(2));

  cf_emitter #(
    .NUM_COLS(NUM_COLS),
    .SAMPLE_W(SAMPLE_W),
    .ROW_W   (ROW_W),
    .COL_W   (COL_W)
  ) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_row_i (load_row),
    .load_data_i(row2_q),
    .load_mask_i(mark),
    .full_i     (fifo_full),
    .idle_o     (em_idle),
    .push_o     (em_push),
    .rec_row_o  (em_row),
    .rec_col_o  (em_col),
    .rec_val_o  (em_val)
  );

  cf_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (em_push),
    .data_i ({em_row, em_col, em_val}),
    .full_o (fifo_full),
    .pop_i  (rec_ready_i),
    .valid_o(fifo_valid),
    .data_o (fifo_out)
  );

  assign rec_valid_o  = fifo_valid;
  assign {rec_row_o, rec_col_o, rec_val_o} = fifo_out;
  assign frame_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_RUN;
      flush_second_q <= 1'b0;
      k_q            <= '0;
      row1_q         <= '0;
      row2_q         <= '0;
      h1_q           <= '0;
      h2_q           <= '0;
      h3_q           <= '0;
      done_q         <= 1'b0;
    end else begin
      done_q <= drain_done;
      if (drain_done) begin
        st_q   <= ST_RUN;
        k_q    <= '0;
        row1_q <= '0;
        row2_q <= '0;
        h1_q   <= '0;
        h2_q   <= '0;
        h3_q   <= '0;
      end else if (step) begin
        row2_q <= row1_q;
        row1_q <= accept ? pix_data_i : '0;
        h3_q   <= h2_q;
        h2_q   <= h1_q;
        h1_q   <= new_h;
        k_q    <= k_q + 1'b1;
        if (accept && pix_eof_i) begin
          st_q           <= ST_FLUSH;
          flush_second_q <= 1'b0;
        end else if (flush_step) begin
          if (flush_second_q) st_q <= ST_DRAIN;
          else flush_second_q <= 1'b1;
        end
      end
    end
  end

  // ordering tracker for a_r5_row_major
  logic             have_last_q;
  logic [ROW_W-1:0] last_row_q;
  logic [COL_W-1:0] last_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last_q <= 1'b0;
      last_row_q  <= '0;
      last_col_q  <= '0;
    end else if (frame_done_o) begin
      have_last_q <= 1'b0;
    end else if (rec_valid_o && rec_ready_i) begin
      have_last_q <= 1'b1;
      last_row_q  <= rec_row_o;
      last_col_q  <= rec_col_o;
    end
  end

  a_r5_row_major: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_ready_i && have_last_q) |->
      ((rec_row_o > last_row_q) || ((rec_row_o == last_row_q) && (rec_col_o > last_col_q))));

  a_r9_stall_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && pix_ready_o && pix_eof_i) |=> !pix_ready_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r10_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !rec_valid_o);
endmodule

// File: tb/cluster_sparsifier_bench.sv
module cluster_sparsifier_bench;
  localparam int NC   = 8;
  localparam int SW   = 5;
  localparam int RW   = 6;
  localparam int CW   = 3;
  localparam int THR  = 20;
  localparam int MAXR = 16;

  // {rows[15:8], pattern[7:4], unused[3:1], backpressure[0]}
  localparam logic [15:0] VEC [11] = '{
    {8'd8,  4'd0, 3'd0, 1'b0},
    {8'd8,  4'd1, 3'd0, 1'b0},
    {8'd8,  4'd2, 3'd0, 1'b0},
    {8'd8,  4'd3, 3'd0, 1'b0},
    {8'd8,  4'd4, 3'd0, 1'b1},
    {8'd12, 4'd5, 3'd0, 1'b0},
    {8'd12, 4'd5, 3'd0, 1'b1},
    {8'd1,  4'd6, 3'd0, 1'b0},
    {8'd2,  4'd6, 3'd0, 1'b1},
    {8'd16, 4'd3, 3'd0, 1'b1},
    {8'd3,  4'd6, 3'd0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pix_valid = 1'b0, pix_eof = 1'b0, rec_ready = 1'b0;
  logic [NC*SW-1:0]  pix_data = '0;
  logic              pix_ready, rec_valid, frame_done;
  logic [RW-1:0]     rec_row;
  logic [CW-1:0]     rec_col;
  logic [SW-1:0]     rec_val;

  always #5 clk = ~clk;

  cluster_sparsifier #(
    .NUM_COLS(NC), .SAMPLE_W(SW), .ROW_W(RW), .THRESHOLD(THR), .FIFO_DEPTH(4)
  ) u_cluster_sparsifier (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_valid_i(pix_valid), .pix_ready_o(pix_ready), .pix_eof_i(pix_eof),
    .pix_data_i(pix_data),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready),
    .rec_row_o(rec_row), .rec_col_o(rec_col), .rec_val_o(rec_val),
    .frame_done_o(frame_done)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [SW-1:0] img [MAXR][NC];
  int ex_row [MAXR*NC], ex_col [MAXR*NC], ex_val [MAXR*NC];
  int n_exp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pix(input int pat, input int n, input int y, input int x);
    case (pat)
      1: return ((y == 3 || y == 4) && (x == 3 || x == 4)) ? 5'd5 : 5'd0;
      2: return ((y == 3 || y == 4) && (x == 3 || x == 4)) ? ((y == 4 && x == 4) ? 5'd4 : 5'd5) : 5'd0;
      3: return ((y < 2 && x < 2) || (y >= n - 2 && x >= NC - 2)) ? 5'd8 : 5'd0;
      4: return (((y == 2 || y == 3) && (x == 2 || x == 3)) ||
                 ((y == 3 || y == 4) && (x == 3 || x == 4))) ? 5'd5 : 5'd0;
      5: return SW'((y * 5 + x * 3 + y * x) % 9);
      6: return 5'd31;
      default: return 5'd0;
    endcase
  endfunction

  // direct reference: mark pixel if any hit window lies within reach
  task automatic build(input int n, input int pat);
    n_exp = 0;
    for (int y = 0; y < n; y++)
      for (int x = 0; x < NC; x++) img[y][x] = pix(pat, n, y, x);
    for (int y = 0; y < n; y++) begin
      for (int x = 0; x < NC; x++) begin
        bit m = 0;
        for (int r = 0; r < n - 1; r++)
          for (int c = 0; c < NC - 1; c++)
            if ((int'(img[r][c]) + int'(img[r][c+1]) + int'(img[r+1][c]) + int'(img[r+1][c+1]) >= THR)
                && (y >= r - 1) && (y <= r + 2) && (x >= c - 1) && (x <= c + 2)) m = 1;
        if (m) begin
          ex_row[n_exp] = y; ex_col[n_exp] = x; ex_val[n_exp] = int'(img[y][x]);
          n_exp++;
        end
      end
    end
  endtask

  function automatic string pat_req(input int pat);
    case (pat)
      0: return "R7";
      1: return "R1";
      2: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic run_frame(input int n, input int pat, input bit bp);
    int row_i = 0, got = 0, cyc = 0, ready_err = 0;
    bit done = 0, eof_acc = 0, hold_pend = 0;
    int hr = 0, hc = 0, hv = 0;
    build(n, pat);
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (hold_pend)
        chk(rec_valid && int'(rec_row) == hr && int'(rec_col) == hc && int'(rec_val) == hv,
            "R8", "stalled record changed", int'(rec_col), hc);
      if (frame_done) begin
        done = 1;
        chk(got == n_exp, pat_req(pat), "record count at frame end", got, n_exp);
        chk(!rec_valid, "R10", "valid during frame done", int'(rec_valid), 0);
      end else if (eof_acc && pix_ready) begin
        ready_err++;
      end
      if (row_i < n) begin
        pix_valid = 1'b1;
        pix_eof   = (row_i == n - 1);
        for (int x = 0; x < NC; x++) pix_data[x*SW +: SW] = img[row_i][x];
      end else begin
        pix_valid = 1'b0;
        pix_eof   = 1'b0;
      end
      rec_ready = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (pix_valid && pix_ready) begin
        if (pix_eof) eof_acc = 1;
        row_i++;
      end
      if (rec_valid && rec_ready && !done) begin
        if (got < n_exp) begin
          chk(int'(rec_row) == ex_row[got], "R5", "record row", int'(rec_row), ex_row[got]);
          chk(int'(rec_col) == ex_col[got], "R5", "record column", int'(rec_col), ex_col[got]);
          chk(int'(rec_val) == ex_val[got], "R6", "record value", int'(rec_val), ex_val[got]);
        end else begin
          chk(0, "R7", "record beyond expected set", got + 1, n_exp);
        end
        got++;
      end
      hold_pend = rec_valid && !rec_ready;
      hr = int'(rec_row); hc = int'(rec_col); hv = int'(rec_val);
    end
    chk(done, "R10", "frame done pulse seen", int'(done), 1);
    chk(ready_err == 0, "R9", "input ready cycles during flush", ready_err, 0);
    pix_valid = 1'b0;
    pix_eof   = 1'b0;
    rec_ready = 1'b0;
    @(negedge clk);
    chk(!frame_done, "R10", "frame done longer than one cycle", int'(frame_done), 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual 0 expected 1 (run completion)");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rec_valid, "R11", "valid in reset", int'(rec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rec_valid, "R11", "valid after reset", int'(rec_valid), 0);
    chk(!frame_done, "R11", "frame done after reset", int'(frame_done), 0);
    chk(pix_ready, "R11", "input ready after reset", int'(pix_ready), 1);

    foreach (VEC[i]) begin
      run_frame(int'(VEC[i][15:8]), int'(VEC[i][7:4]), VEC[i][0]);
    end

    // reset in the middle of a dense frame
    build(6, 6);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_eof   = 1'b0;
      for (int x = 0; x < NC; x++) pix_data[x*SW +: SW] = img[0][x];
    end
    @(negedge clk);
    pix_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rec_valid, "R11", "valid after mid-frame reset", int'(rec_valid), 0);
    chk(pix_ready, "R11", "ready after mid-frame reset", int'(pix_ready), 1);
    chk(!frame_done, "R11", "done after mid-frame reset", int'(frame_done), 0);

    // clean frame after the abort; threshold exactly met
    run_frame(8, 1, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule